// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

An 8-bit free-running up-counter with one capture pin and two snapshot registers. The capture pin is first synchronized into the counter clock domain. After that, a rising transition stores the current count in one register and a falling transition stores it in the other. A control bit picks which of the two transitions sets a sticky capture flag. A separate enable bit gates that flag onto an interrupt line, and it leaves the flag itself untouched.

A host reaches the block through a plain register port. A write takes effect at a clock edge, and the read data is a combinational function of the address. The host can read both snapshots, the control bits and the flag. It can write the control bits and clear the flag by writing 0 to it. The counter is never visible to the host and never writable. No part of the block moves a data stream, so no valid/ready handshake is involved and back-pressure cannot arise. Every pin is plain control or status.

Top module: `dect_top`

## Requirements
- R1: After reset, the counter, both snapshot registers, the control bits and the flag are 0, and `irq_o` is low.
- R2: The counter advances by 1 at each clock edge where `tick_en` is high, holds while `tick_en` is low, and wraps from 0xFF to 0x00.
- R3: The capture pin is sampled at clock edge n. If it was 0 at the previous sample and 1 at edge n, then the rising snapshot (address 0) is loaded at edge n+2 with the count present just before edge n+2.
- R4: In the same way, a transition from 1 to 0 sampled at edge n loads the falling snapshot (address 1) at edge n+2.
- R5: Control bit 0 (address 2) selects the flagging edge. When it is 1, only falling captures set the flag. When it is 0, only rising captures set it. The other edge still captures but leaves the flag unchanged.
- R6: `irq_o` is high exactly while the flag and control bit 1 (the enable) are both 1. Clearing the enable drops `irq_o` and leaves the flag set.
- R7: The flag is status bit 0 (address 3). Writing 0 to it clears it, and writing 1 to it has no effect. A capture that sets the flag in the same cycle as a clearing write leaves the flag at 1.
- R8: Writes to addresses 0 and 1 leave both snapshots unchanged. No address maps the counter.
- R9: A control write is visible in the address-2 readback only after the clock edge that accepts it. The readback shows the enable in bit 1, the select in bit 0, and zeros in all other bits.
- R10: A level held for two sampled cycles is enough. A two-cycle high pulse produces both a rising and a falling capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| cap_in | input | 1 | Asynchronous capture pin |
| host_wr | input | 1 | Write strobe, accepted at the clock edge |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The pin is driven with single rising and falling steps under each setting of the edge select, so the bench can tell the flagging edge apart from the non-flagging edge. Captures taken with `tick_en` low and after more than 256 counting cycles show whether the counter holds and wraps correctly. A two-cycle pulse exercises the shortest level that the block must resolve. A clearing write is placed in the same edge as a flag-setting capture to show which of the two has priority.

// File: rtl/dect_pkg.sv
package dect_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADR_CAP_RISE = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_CAP_FALL = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_CTRL     = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_STAT     = 2'd3;

  typedef struct packed {
    logic irq_en;
    logic sel_fall;
  } ctrl_t;
endpackage

// File: rtl/dect_sync_edge.sv
module dect_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[TOP-1:0], din};
      prev_q <= sync_q[TOP];
    end
  end

  assign rise_o = sync_q[TOP] & ~prev_q;
  assign fall_o = ~sync_q[TOP] & prev_q;

  // R10
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/dect_counter.sv
module dect_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_o <= '0;
    else if (tick_en) count_o <= count_o + 1'b1;
  end

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && count_o == CNT_MAX) |=> (count_o == '0));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count_o));
endmodule

// File: rtl/dect_capture_bank.sv
module dect_capture_bank
  import dect_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic [CNT_W-1:0] count,
  input  logic             wr_ctrl,
  input  logic             wr_stat,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cap_rise_o,
  output logic [CNT_W-1:0] cap_fall_o,
  output ctrl_t            ctrl_o,
  output logic             flag_o
);
  logic flag_set;
  logic flag_clr;

  assign flag_set = ctrl_o.sel_fall ? fall_evt : rise_evt;
  assign flag_clr = wr_stat & ~wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_rise_o <= '0;
      cap_fall_o <= '0;
      ctrl_o     <= '0;
      flag_o     <= 1'b0;
    end else begin
      if (rise_evt) cap_rise_o <= count;
      if (fall_evt) cap_fall_o <= count;
      if (wr_ctrl)  ctrl_o <= ctrl_t'(wdata[1:0]);
      if (flag_set)      flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
    end
  end

  // R3
  rise_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (cap_rise_o == $past(count)));
  // R4
  fall_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (cap_fall_o == $past(count)));
  // R8
  rise_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(cap_rise_o));
  // R5
  sel_rise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !ctrl_o.sel_fall) |=> flag_o);
  // R5
  sel_fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && ctrl_o.sel_fall) |=> flag_o);
  // R5
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(rise_evt || fall_evt));
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !rise_evt && !fall_evt) |=> !flag_o);
endmodule

// File: rtl/dect_top.sv
module dect_top
  import dect_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  cap_in,
  input  logic                  host_wr,
  input  logic [REG_ADDR_W-1:0] host_addr,
  input  logic [CNT_W-1:0]      host_wdata,
  output logic [CNT_W-1:0]      host_rdata,
  output logic                  irq_o
);
  logic             rise_evt, fall_evt;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap_rise, cap_fall;
  ctrl_t            ctrl;
  logic             flag;
  logic             wr_ctrl, wr_stat;

  dect_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in),
    .rise_o(rise_evt), .fall_o(fall_evt)
  );

  dect_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count_o(count)
  );

  assign wr_ctrl = host_wr && (host_addr == ADR_CTRL);
  assign wr_stat = host_wr && (host_addr == ADR_STAT);

  dect_capture_bank #(.CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .count(count),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wdata(host_wdata),
    .cap_rise_o(cap_rise), .cap_fall_o(cap_fall),
    .ctrl_o(ctrl), .flag_o(flag)
  );

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADR_CAP_RISE: host_rdata = cap_rise;
      ADR_CAP_FALL: host_rdata = cap_fall;
      ADR_CTRL:     host_rdata[1:0] = ctrl;
      default:      host_rdata[0] = flag;
    endcase
  end

  assign irq_o = flag & ctrl.irq_en;

  // R6
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.irq_en) |-> !irq_o);
  // R9
  ctrl_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ctrl) |-> $stable(ctrl));
endmodule

// File: tb/tb_dect_top.sv
module tb_dect_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       cap_in = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m = 8'd0;

  typedef struct { logic rise; logic [7:0] val; } exp_t;
  exp_t sbq[$];
  event chk_ev;

  dect_top dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_in(cap_in),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m <= 8'd0;
    else if (tick_en) m <= m + 8'd1;

  task automatic chk(input string rq, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", rq, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic drive_edge(input logic v);
    @(negedge clk);
    cap_in = v;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    sbq.push_back('{v, m});
    @(posedge clk);
    @(negedge clk);
    ->chk_ev;
    #2;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (sbq.size() > 0) begin
        exp_t e;
        logic [7:0] d;
        e = sbq.pop_front();
        rd(e.rise ? 2'd0 : 2'd1, d);
        chk(e.rise ? "R3 rise snapshot" : "R4 fall snapshot", d, e.val);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got running expected done");
    finish_run();
  end

  initial begin
    logic [7:0] d, a0, a1, e_r, e_f;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), d);
      chk("R1 reset reg", d, 8'd0);
    end
    chk("R1 irq low", {7'd0, irq_o}, 8'd0);
    @(negedge clk); rst_n = 1'b1; tick_en = 1'b1;
    repeat (5) @(negedge clk);

    // R3 / R5: rising edge flags with select 0
    drive_edge(1'b1);
    rd(2'd3, d); chk("R5 rise sets flag", d, 8'd1);
    chk("R6 irq off when disabled", {7'd0, irq_o}, 8'd0);
    // R7 write 1 keeps, write 0 clears
    host_write(2'd3, 8'd1); rd(2'd3, d); chk("R7 write 1 no effect", d, 8'd1);
    host_write(2'd3, 8'd0); rd(2'd3, d); chk("R7 clear", d, 8'd0);
    // R4 / R5 falling capture leaves flag with select 0
    drive_edge(1'b0);
    rd(2'd3, d); chk("R5 fall ignored by select 0", d, 8'd0);

    // R9 control write latency and readback
    @(negedge clk);
    host_wr = 1'b1; host_addr = 2'd2; host_wdata = 8'hFF;
    #1; chk("R9 before edge", host_rdata, 8'd0);
    @(negedge clk); host_wr = 1'b0;
    rd(2'd2, d); chk("R9 after edge", d, 8'd3);

    drive_edge(1'b1);
    rd(2'd3, d); chk("R5 rise ignored by select 1", d, 8'd0);
    chk("R6 irq low without flag", {7'd0, irq_o}, 8'd0);
    drive_edge(1'b0);
    rd(2'd3, d); chk("R5 fall sets flag", d, 8'd1);
    chk("R6 irq high", {7'd0, irq_o}, 8'd1);
    host_write(2'd2, 8'd1);
    #1; chk("R6 irq drops with enable", {7'd0, irq_o}, 8'd0);
    rd(2'd3, d); chk("R6 flag kept", d, 8'd1);

    // R8 snapshots read-only
    rd(2'd0, a0); rd(2'd1, a1);
    host_write(2'd0, 8'hA5); host_write(2'd1, 8'h5A);
    rd(2'd0, d); chk("R8 rise snapshot unwritable", d, a0);
    rd(2'd1, d); chk("R8 fall snapshot unwritable", d, a1);

    // R7 set wins over simultaneous clear
    host_write(2'd2, 8'd0);
    host_write(2'd3, 8'd0);
    @(negedge clk); cap_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    e_r = m;
    host_wr = 1'b1; host_addr = 2'd3; host_wdata = 8'd0;
    @(negedge clk); host_wr = 1'b0;
    rd(2'd3, d); chk("R7 set beats clear", d, 8'd1);
    rd(2'd0, d); chk("R3 snapshot with clear", d, e_r);

    // R2 hold while tick_en low
    @(negedge clk); tick_en = 1'b0;
    drive_edge(1'b0);
    drive_edge(1'b1);
    rd(2'd0, a0); rd(2'd1, a1);
    chk("R2 count holds", a0, a1);
    // R2 wrap after more than 256 ticks
    @(negedge clk); tick_en = 1'b1;
    repeat (300) @(negedge clk);
    drive_edge(1'b0);

    // R10 two-cycle pulse
    repeat (4) @(negedge clk);
    cap_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); e_r = m; cap_in = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); e_f = m;
    @(posedge clk); @(negedge clk);
    rd(2'd0, d); chk("R10 pulse rise", d, e_r);
    rd(2'd1, d); chk("R10 pulse fall", d, e_f);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule